// File: doc/BRIEF.md
# PRBS Link Error-Rate Tester

This block measures the bit error rate of a 16-bit parallel serial link. On the transmit side it either forwards normal traffic or, when test mode is enabled, sends a pseudo-random sequence. The sequence comes from a 31-stage shift register with taps x^31 + x^28 + 1 and advances sixteen bits on every link clock. On the receive side it has two identical checkers, one for the main port and one for the redundant port, so both legs of a 1:1 protected link can be measured at the same time.

Each checker runs a small state machine. `SEED_A` captures one received word. `SEED_B` takes the newest 31 received bits and loads them as the checker's own register state. If those 31 bits are all zero, the checker stays in `SEED_B` and slides forward one word at a time. `HUNT` compares incoming words with the locally predicted pattern. Any mismatch takes `HUNT` back to `SEED_A`. After 64 clean words in a row, `HUNT` moves to `LOCKED`. In `LOCKED`, every errored bit is added to a saturating counter. A word with eight or more errored bits is a sync-loss event and returns the checker to `SEED_A`. Software reads a counter by sampling it and pulsing that port's clear strobe.

Top module: `prbs_bert`

## Requirements
- R1: The transmitted pattern obeys b[n] = b[n-31] XOR b[n-28], sixteen bits per clock, and bit 15 of each word is the earliest bit in time.
- R2: After reset the generator state is all ones, and it advances only while test mode is enabled, so the first two pattern words are 16'h0000 and 16'h000E. An all-zero generator state is replaced by all ones.
- R3: `tx_word` is registered. One clock after an edge with `tx_prbs_en` high it carries the pattern word. With `tx_prbs_en` low it carries the `tx_traffic` value from that edge.
- R4: Seeding uses the newest 31 received bits: bits 14:0 of the previous word followed by all 16 bits of the current word. An all-zero seed is never loaded, so a constant-zero input never locks.
- R5: `*_locked` rises only after 64 consecutive error-free words follow seeding. An errored word while hunting restarts seeding.
- R6: While locked, the number of bits that differ between the received word and the predicted word is added to the port's counter. Words received while not locked add nothing.
- R7: A locked word with fewer than 8 errored bits keeps lock. A word with 8 or more errored bits is still counted, but it drops lock on the next clock.
- R8: A clear strobe on a port sets that counter to the errors of the word in the same cycle, so an error coinciding with a read is kept and not lost.
- R9: Each counter saturates at its all-ones value and does not wrap.
- R10: The two checkers are independent: errors, clears and lock state of one port never change the other port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_prbs_en | input | 1 | 1 selects the test pattern, 0 selects traffic |
| tx_traffic | input | 16 | Normal transmit traffic word |
| tx_word | output | 16 | Word sent to the serializer |
| rx_main | input | 16 | Word from the main receive port |
| rx_red | input | 16 | Word from the redundant receive port |
| rd_clr_main | input | 1 | Clear strobe for the main counter |
| rd_clr_red | input | 1 | Clear strobe for the redundant counter |
| main_locked | output | 1 | Main checker is in LOCKED |
| red_locked | output | 1 | Redundant checker is in LOCKED |
| main_err_cnt | output | CNT_W | Main errored-bit count |
| red_err_cnt | output | CNT_W | Redundant errored-bit count |

## Verification
A counter clear and a counted error word can occur in the same clock. The bench first loads the main counter with a known value. It then drives a two-bit error mask on the main port in the same cycle as the clear strobe and expects the counter to read exactly 2, not 0 and not the old value plus 2. Meanwhile the redundant counter holds an earlier count, which must stay unchanged through the main clear.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;
    localparam int LFSR_LEN = 31;
    localparam int TAP_POS  = 28;
    localparam int WORD_W   = 16;
    localparam int POP_W    = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [LFSR_LEN-1:0] st;
        logic [WORD_W-1:0]   word;
    } prbs_step_t;

    // Advance the sequence by one word; st[0] is the newest bit.
    function automatic prbs_step_t prbs_step(input logic [LFSR_LEN-1:0] s);
        prbs_step_t r;
        logic [LFSR_LEN-1:0] t;
        logic nb;
        t = s;
        r.word = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            nb = t[LFSR_LEN-1] ^ t[TAP_POS-1];
            r.word[i] = nb;
            t = {t[LFSR_LEN-2:0], nb};
        end
        r.st = t;
        return r;
    endfunction

    function automatic logic [POP_W-1:0] pop16(input logic [WORD_W-1:0] v);
        logic [POP_W-1:0] c;
        c = '0;
        for (int i = 0; i < WORD_W; i++) c = c + POP_W'(v[i]);
        return c;
    endfunction

    typedef enum logic [1:0] {
        SEED_A = 2'd0,
        SEED_B = 2'd1,
        HUNT   = 2'd2,
        LOCKED = 2'd3
    } chk_state_t;
endpackage

// File: rtl/prbs_tx.sv
module prbs_tx
    import prbs_bert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] traffic,
    output logic [WORD_W-1:0] word_out
);
    logic [LFSR_LEN-1:0] gen_st;
    prbs_step_t          stp;

    always_comb stp = prbs_step(gen_st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_st   <= '1;
            word_out <= '0;
        end else begin
            word_out <= en ? stp.word : traffic;
            if (gen_st == '0)
                gen_st <= '1;
            else if (en)
                gen_st <= stp.st;
        end
    end
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_bert_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int LOCK_WORDS = 64,
    parameter int LOSS_BITS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx,
    input  logic              rd_clr,
    output logic              locked,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam int GW = $clog2(LOCK_WORDS);
    localparam logic [GW-1:0]    LOCK_LAST = GW'(LOCK_WORDS - 1);
    localparam logic [POP_W-1:0] LOSS_V    = POP_W'(LOSS_BITS);

    chk_state_t          state, nxt;
    logic [WORD_W-1:0]   prev_word;
    logic [LFSR_LEN-1:0] exp_st, seed;
    logic [GW-1:0]       good_cnt;
    prbs_step_t          stp;
    logic [POP_W-1:0]    nerr, word_err;
    logic [CNT_W:0]      sum;

    always_comb begin
        stp      = prbs_step(exp_st);
        nerr     = pop16(rx ^ stp.word);
        seed     = {prev_word[LFSR_LEN-WORD_W-1:0], rx};
        word_err = (state == LOCKED) ? nerr : '0;
        sum      = (rd_clr ? '0 : {1'b0, err_cnt}) + {{(CNT_W + 1 - POP_W){1'b0}}, word_err};
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            SEED_A: nxt = SEED_B;
            SEED_B: nxt = (seed != '0) ? HUNT : SEED_B;
            HUNT: begin
                if (nerr != '0)              nxt = SEED_A;
                else if (good_cnt == LOCK_LAST) nxt = LOCKED;
            end
            LOCKED: if (nerr >= LOSS_V) nxt = SEED_A;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEED_A;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_word <= '0;
            exp_st    <= '1;
            good_cnt  <= '0;
            err_cnt   <= '0;
        end else begin
            prev_word <= rx;
            if (state == SEED_B && seed != '0)
                exp_st <= seed;
            else if (state == HUNT || state == LOCKED)
                exp_st <= stp.st;
            good_cnt <= (state == HUNT && nerr == '0) ? good_cnt + 1'b1 : '0;
            err_cnt  <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    assign locked = (state == LOCKED);
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert
    import prbs_bert_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int LOCK_WORDS = 64,
    parameter int LOSS_BITS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_prbs_en,
    input  logic [15:0]       tx_traffic,
    output logic [15:0]       tx_word,
    input  logic [15:0]       rx_main,
    input  logic [15:0]       rx_red,
    input  logic              rd_clr_main,
    input  logic              rd_clr_red,
    output logic              main_locked,
    output logic              red_locked,
    output logic [CNT_W-1:0]  main_err_cnt,
    output logic [CNT_W-1:0]  red_err_cnt
);
    localparam int NPORT = 2;

    logic [WORD_W-1:0] rx_arr  [NPORT];
    logic              clr_arr [NPORT];
    logic              lk_arr  [NPORT];
    logic [CNT_W-1:0]  cnt_arr [NPORT];

    assign rx_arr[0]  = rx_main;
    assign rx_arr[1]  = rx_red;
    assign clr_arr[0] = rd_clr_main;
    assign clr_arr[1] = rd_clr_red;

    prbs_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_prbs_en),
        .traffic  (tx_traffic),
        .word_out (tx_word)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        prbs_chk #(
            .CNT_W      (CNT_W),
            .LOCK_WORDS (LOCK_WORDS),
            .LOSS_BITS  (LOSS_BITS)
        ) u_chk (
            .clk     (clk),
            .rst_n   (rst_n),
            .rx      (rx_arr[g]),
            .rd_clr  (clr_arr[g]),
            .locked  (lk_arr[g]),
            .err_cnt (cnt_arr[g])
        );
    end

    assign main_locked  = lk_arr[0];
    assign red_locked   = lk_arr[1];
    assign main_err_cnt = cnt_arr[0];
    assign red_err_cnt  = cnt_arr[1];
endmodule

// File: rtl/prbs_bert_sva.sv
module prbs_bert_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_prbs_en,
    input logic [15:0]      tx_traffic,
    input logic [15:0]      tx_word,
    input logic             rd_clr_main,
    input logic             rd_clr_red,
    input logic             main_locked,
    input logic             red_locked,
    input logic [CNT_W-1:0] main_err_cnt,
    input logic [CNT_W-1:0] red_err_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] WMAX = CNT_W'(16);

    a_r3_traffic_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_prbs_en |=> tx_word == $past(tx_traffic));

    a_r6_main_idle_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_locked && !rd_clr_main) |=> main_err_cnt == $past(main_err_cnt));

    a_r6_red_idle_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!red_locked && !rd_clr_red) |=> red_err_cnt == $past(red_err_cnt));

    a_r8_main_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_main |=> main_err_cnt <= WMAX);

    a_r8_red_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_red |=> red_err_cnt <= WMAX);

    a_r9_main_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (main_err_cnt == CMAX && !rd_clr_main) |=> main_err_cnt == CMAX);

    a_r9_main_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_main |=> main_err_cnt >= $past(main_err_cnt));

    a_r9_red_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_red |=> red_err_cnt >= $past(red_err_cnt));
endmodule

bind prbs_bert prbs_bert_sva #(.CNT_W(CNT_W)) u_sva (.*);

// File: tb/tb_prbs_bert.sv
module tb_prbs_bert;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_prbs_en = 1'b0;
    logic [15:0]   tx_traffic = '0;
    logic [15:0]   tx_word;
    logic [15:0]   mask_m = '0, mask_r = '0;
    logic          red_zero = 1'b1;
    logic          rd_clr_main = 1'b0, rd_clr_red = 1'b0;
    logic          main_locked, red_locked;
    logic [CW-1:0] main_err_cnt, red_err_cnt;
    logic [15:0]   rx_main, rx_red;

    int   n_chk = 0, n_fail = 0;
    logic mon_on = 1'b0;
    logic [63:0] hist = '0;
    int   nbits = 0;

    assign rx_main = tx_word ^ mask_m;
    assign rx_red  = red_zero ? 16'h0000 : (tx_word ^ mask_r);

    always #2.5 clk = ~clk;

    prbs_bert #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_prbs_en(tx_prbs_en), .tx_traffic(tx_traffic),
        .tx_word(tx_word), .rx_main(rx_main), .rx_red(rx_red),
        .rd_clr_main(rd_clr_main), .rd_clr_red(rd_clr_red),
        .main_locked(main_locked), .red_locked(red_locked),
        .main_err_cnt(main_err_cnt), .red_err_cnt(red_err_cnt)
    );

    // {main mask, red mask, expected main count, expected red count}
    localparam logic [47:0] VECS [0:7] = '{
        {16'h0001, 16'h0000, 8'd1, 8'd0},
        {16'h8000, 16'h0000, 8'd1, 8'd0},
        {16'h0000, 16'h0100, 8'd0, 8'd1},
        {16'h0003, 16'h8001, 8'd2, 8'd2},
        {16'h7F00, 16'h0000, 8'd7, 8'd0},
        {16'h0000, 16'h00FE, 8'd0, 8'd7},
        {16'h1248, 16'h0810, 8'd4, 8'd2},
        {16'h0000, 16'h0000, 8'd0, 8'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1 recurrence monitor on the transmitted stream
    task automatic tick();
        logic b;
        @(negedge clk);
        if (mon_on) begin
            logic ok;
            ok = 1'b1;
            for (int j = 15; j >= 0; j--) begin
                b = tx_word[j];
                if (nbits >= 31 && b != (hist[30] ^ hist[27])) ok = 1'b0;
                hist = {hist[62:0], b};
                nbits++;
            end
            if (nbits > 47) check("R1 recurrence", {31'd0, ok}, 32'd1);
        end
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        tick(); tick();
        check("reset tx_word", {16'd0, tx_word}, 32'd0);
        check("reset locks", {30'd0, main_locked, red_locked}, 32'd0);
        check("reset counts", {16'd0, main_err_cnt, red_err_cnt}, 32'd0);
        rst_n = 1'b1;
        tick();
        tx_traffic = 16'hA5C3;
        tick();
        check("R3 traffic pass", {16'd0, tx_word}, 32'h0000A5C3);
        tx_traffic = 16'h0000;
        tick(); tick();
        // enable pattern
        tx_prbs_en = 1'b1;
        tick();
        check("R2 first word", {16'd0, tx_word}, 32'h0000);
        mon_on = 1'b1;
        for (int j = 15; j >= 0; j--) begin hist = {hist[62:0], tx_word[j]}; nbits++; end
        tick();
        check("R2 second word", {16'd0, tx_word}, 32'h000E);
        for (int i = 0; i < 40; i++) tick();
        check("R5 no early lock", {31'd0, main_locked}, 32'd0);
        k = 0;
        while (!main_locked && k < 100) begin tick(); k++; end
        check("R5 main locks", {31'd0, main_locked}, 32'd1);
        check("R4 zero input never locks", {31'd0, red_locked}, 32'd0);
        red_zero = 1'b0;
        k = 0;
        while (!red_locked && k < 150) begin tick(); k++; end
        check("R10 red locks", {31'd0, red_locked}, 32'd1);
        check("R6 clean counts", {16'd0, main_err_cnt, red_err_cnt}, 32'd0);

        // vector table: R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            mask_m = VECS[v][47:32];
            mask_r = VECS[v][31:16];
            tick();
            mask_m = '0; mask_r = '0;
            check("R6 main count", {24'd0, main_err_cnt}, {24'd0, VECS[v][15:8]});
            check("R6 red count",  {24'd0, red_err_cnt},  {24'd0, VECS[v][7:0]});
            check("R7 lock kept", {30'd0, main_locked, red_locked}, 32'd3);
            rd_clr_main = 1'b1; rd_clr_red = 1'b1;
            tick();
            rd_clr_main = 1'b0; rd_clr_red = 1'b0;
            check("R8 cleared", {16'd0, main_err_cnt, red_err_cnt}, 32'd0);
        end

        // R8 clear coinciding with an error; R10 red unaffected
        mask_m = 16'h0001; mask_r = 16'h0400;
        tick();
        mask_r = 16'h0000; mask_m = 16'h0005; rd_clr_main = 1'b1;
        tick();
        mask_m = '0; rd_clr_main = 1'b0;
        check("R8 clear with error", {24'd0, main_err_cnt}, 32'd2);
        check("R10 red untouched", {24'd0, red_err_cnt}, 32'd1);

        // R9 saturation
        mask_m = 16'h007F;
        for (int i = 0; i < 40; i++) tick();
        mask_m = '0;
        check("R9 saturate", {24'd0, main_err_cnt}, 32'd255);
        check("R7 seven bits keep lock", {31'd0, main_locked}, 32'd1);

        // R7 sync loss with 8 errored bits
        rd_clr_main = 1'b1;
        tick();
        rd_clr_main = 1'b0;
        mask_m = 16'h00FF;
        tick();
        mask_m = 16'h0001;
        check("R7 eight bits counted", {24'd0, main_err_cnt}, 32'd8);
        tick();
        check("R7 lock dropped", {31'd0, main_locked}, 32'd0);
        check("R10 red stays locked", {31'd0, red_locked}, 32'd1);
        for (int i = 0; i < 6; i++) tick();
        mask_m = '0;
        check("R6 unlocked errors ignored", {24'd0, main_err_cnt}, 32'd8);
        k = 0;
        while (!main_locked && k < 150) begin tick(); k++; end
        check("R5 relock", {31'd0, main_locked}, 32'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule